// File: doc/BRIEF.md
# Cross-Lane Operand Permutation Unit

This block sits in front of a wide SIMD arithmetic stage and supplies one of its source operands. For every lane of a wave it picks the 32-bit value of some other lane of the same wave. The choice comes from a small fixed set of patterns rather than a general crossbar:

- quad permutes;
- half-row and full-row mirrors;
- row-local shifts and rotates;
- cross-row broadcasts;
- whole-wave single-step shifts and rotates.

The block also forms a per-lane write enable, which the arithmetic stage uses to commit or drop each lane's result. That enable folds together four things:

- a row mask;
- a bank mask;
- the active-lane mask;
- whether the chosen source lane was usable.

A zero-fill flag selects how an unusable source is handled. When the flag is set, the lane reads zero and still writes. When it is clear, the lane's write is suppressed, so the destination keeps its old value. The permuted vector and the enables are registered once, so both appear one clock after the controls.

A row is 16 lanes, so lane L is in row L/16 at row position L mod 16. The bank of lane L is L mod 4. The lane count is a parameter (default 64).

Top module: `xlane_perm_unit`

## Requirements
- R1: With mode code 0 (quad), lane L reads lane 4*(L/4)+q, where q is the 2-bit field quad_sel[2*(L mod 4)+1 : 2*(L mod 4)].
- R2: Mode code 1 mirrors within each aligned group of 8 lanes (lane L reads 8*(L/8)+7-(L mod 8)). Mode code 5 mirrors within each 16-lane row (lane L reads 16*(L/16)+15-(L mod 16)).
- R3: Row-local modes use the amount field n (0 to 15), and n = 0 leaves each lane reading itself.
  - Mode 2 (shift left): lane L reads L+n, and the source is invalid if (L mod 16)+n > 15.
  - Mode 3 (shift right): lane L reads L−n, and the source is invalid if (L mod 16) < n.
  - Mode 4 (rotate right): lane L reads 16*(L/16)+((L mod 16)−n mod 16).
- R4: Mode 6 makes every lane of row r>0 read lane 16r−1, and row 0 sources are invalid. Mode 7 makes every lane L≥32 read lane 32*(L/32)−1, and lanes below 32 have invalid sources.
- R5: Whole-wave modes act across all lanes. Lane N−1 has an invalid source in mode 8, and lane 0 has an invalid source in mode 9.
  - Mode 8 (shift left by one): lane L reads L+1.
  - Mode 9 (shift right by one): lane L reads L−1.
  - Mode 10 (rotate left by one): lane L reads (L+1) mod N.
  - Mode 11 (rotate right by one): lane L reads (L−1) mod N.
  - Codes 12 to 15 make each lane read itself.
- R6: A lane in a row whose bit in row_wr_en (bit r for row r) is 0 has its write enable low.
- R7: A lane whose bank bit in bank_wr_en (bit L mod 4) is 0 has its write enable low.
- R8: With zero_fill = 1, a lane whose source is invalid or inactive gets operand 0, and its write enable is not lowered for that reason.
- R9: With zero_fill = 0, a lane whose source is invalid or inactive has its write enable low, and its operand is 0.
- R10: A lane whose own bit in lane_active is 0 never has its write enable high.
- R11: Operand and write enable are registered. They reflect the inputs of the previous rising edge, and both are all-zero after a synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vec | input | NUM_LANES*32 | Wave source values, lane L at bits [32L+31:32L] |
| perm_mode | input | 4 | Pattern code (see R1 to R5) |
| perm_amt | input | 4 | Shift or rotate amount for row modes |
| quad_sel | input | 8 | Quad permute selectors, 2 bits per quad position |
| row_wr_en | input | NUM_LANES/16 | Per-row write enable mask |
| bank_wr_en | input | 4 | Per-bank write enable mask |
| zero_fill | input | 1 | Read zero for unusable sources instead of suppressing the write |
| lane_active | input | NUM_LANES | Active-lane mask |
| opnd_vec | output | NUM_LANES*32 | Registered permuted operand |
| lane_wr_en | output | NUM_LANES | Registered per-lane write enable |

## Verification
Every result of this block, both the operand word and the write enable, is due exactly one rising edge after the controls are applied. There is no other latency path. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. One directed test samples just before that rising edge to confirm that the previous pattern's value is still present. The reset test samples on the falling edge after a reset edge, with non-idle controls applied.

// File: rtl/xlane_pkg.sv
// Shared definitions for the cross-lane permutation unit.
// Assumes a fixed row width of 16 lanes and four banks (bank = lane mod 4).
package xlane_pkg;
    localparam int ROW_LANES  = 16;
    localparam int BANK_COUNT = 4;

    typedef enum logic [3:0] {
        XM_QUAD = 4'd0,
        XM_HMIR = 4'd1,
        XM_RSHL = 4'd2,
        XM_RSHR = 4'd3,
        XM_RROR = 4'd4,
        XM_RMIR = 4'd5,
        XM_BC15 = 4'd6,
        XM_BC31 = 4'd7,
        XM_WSHL = 4'd8,
        XM_WSHR = 4'd9,
        XM_WROL = 4'd10,
        XM_WROR = 4'd11
    } xmode_e;
endpackage

// File: rtl/xlane_src_sel.sv
// Per-lane source index generator.
// For each destination lane it computes which lane feeds it and whether that
// index lies inside the pattern's legal range. It does not look at data or
// at the active mask. Assumes NUM_LANES is a multiple of 16.
module xlane_src_sel
    import xlane_pkg::*;
#(
    parameter int NUM_LANES = 64,
    parameter int LANE_W    = $clog2(NUM_LANES)
) (
    input  logic [3:0]                  mode,
    input  logic [3:0]                  amt,
    input  logic [7:0]                  quad,
    output logic [NUM_LANES*LANE_W-1:0] src_idx,
    output logic [NUM_LANES-1:0]        in_range
);
    for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
        localparam int POS   = L % ROW_LANES;
        localparam int RBASE = L - POS;
        localparam int QPOS  = L % 4;
        localparam int QBASE = L - QPOS;
        localparam int HBASE = L - (L % 8);
        localparam int HBC   = (L / 32) * 32;

        // Select the source lane for this destination according to the pattern.
        always_comb begin
            int  s;
            int  n;
            logic ok;
            n  = {28'd0, amt};
            s  = L;
            ok = 1'b1;
            case (xmode_e'(mode))
                XM_QUAD: s = QBASE + {30'd0, quad[2*QPOS +: 2]};
                XM_HMIR: s = HBASE + 7 - (L % 8);
                XM_RSHL: begin s = L + n; ok = (POS + n) <= (ROW_LANES - 1); end
                XM_RSHR: begin s = L - n; ok = POS >= n; end
                XM_RROR: s = RBASE + ((POS + ROW_LANES - n) % ROW_LANES);
                XM_RMIR: s = RBASE + (ROW_LANES - 1) - POS;
                XM_BC15: begin s = RBASE - 1; ok = RBASE > 0; end
                XM_BC31: begin s = HBC - 1; ok = HBC > 0; end
                XM_WSHL: begin s = L + 1; ok = L < NUM_LANES - 1; end
                XM_WSHR: begin s = L - 1; ok = L > 0; end
                XM_WROL: s = (L + 1) % NUM_LANES;
                XM_WROR: s = (L + NUM_LANES - 1) % NUM_LANES;
                default: s = L;
            endcase
            if (!ok) s = L;
            src_idx[L*LANE_W +: LANE_W] = LANE_W'(s);
            in_range[L] = ok;
        end
    end
endmodule

// File: rtl/xlane_route.sv
// Operand routing and write-enable gating.
// Fetches each lane's source word and qualifies it with the source lane's
// active bit. It forces zero for unusable sources and combines the row, bank,
// destination-active and zero-fill rules into a write enable. Purely
// combinational; the top registers the outputs.
module xlane_route
    import xlane_pkg::*;
#(
    parameter int NUM_LANES = 64,
    parameter int DATA_W    = 32,
    parameter int LANE_W    = $clog2(NUM_LANES),
    parameter int NUM_ROWS  = NUM_LANES / ROW_LANES
) (
    input  logic [NUM_LANES*DATA_W-1:0] src_vec,
    input  logic [NUM_LANES*LANE_W-1:0] src_idx,
    input  logic [NUM_LANES-1:0]        in_range,
    input  logic [NUM_LANES-1:0]        lane_active,
    input  logic [NUM_ROWS-1:0]         row_wr_en,
    input  logic [BANK_COUNT-1:0]       bank_wr_en,
    input  logic                        zero_fill,
    output logic [NUM_LANES*DATA_W-1:0] opnd_c,
    output logic [NUM_LANES-1:0]        wr_c
);
    for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
        logic [LANE_W-1:0] idx;
        logic              usable;
        assign idx = src_idx[L*LANE_W +: LANE_W];

        // Gather the source word; unusable sources read as zero.
        always_comb begin
            usable = in_range[L] & lane_active[idx];
            opnd_c[L*DATA_W +: DATA_W] = usable ? src_vec[idx*DATA_W +: DATA_W] : '0;
        end

        // Combine the masks and the source rule into the lane write enable.
        always_comb begin
            wr_c[L] = lane_active[L] & row_wr_en[L / ROW_LANES]
                    & bank_wr_en[L % BANK_COUNT] & (usable | zero_fill);
        end
    end
endmodule

// File: rtl/xlane_perm_unit.sv
// Cross-lane operand permutation unit (top).
// Selects one source lane per destination lane from a fixed pattern menu.
// Applies row, bank and active masks and the zero-fill rule, then registers
// the operand vector and the write enables once (one-cycle latency).
// Reset is synchronous and active-low, and clears both outputs.
module xlane_perm_unit
    import xlane_pkg::*;
#(
    parameter int NUM_LANES = 64,
    parameter int DATA_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LANES*DATA_W-1:0]       src_vec,
    input  logic [3:0]                        perm_mode,
    input  logic [3:0]                        perm_amt,
    input  logic [7:0]                        quad_sel,
    input  logic [NUM_LANES/ROW_LANES-1:0]    row_wr_en,
    input  logic [BANK_COUNT-1:0]             bank_wr_en,
    input  logic                              zero_fill,
    input  logic [NUM_LANES-1:0]              lane_active,
    output logic [NUM_LANES*DATA_W-1:0]       opnd_vec,
    output logic [NUM_LANES-1:0]              lane_wr_en
);
    localparam int LANE_W   = $clog2(NUM_LANES);
    localparam int NUM_ROWS = NUM_LANES / ROW_LANES;

    logic [NUM_LANES*LANE_W-1:0] src_idx;
    logic [NUM_LANES-1:0]        in_range;
    logic [NUM_LANES*DATA_W-1:0] opnd_c;
    logic [NUM_LANES-1:0]        wr_c;

    xlane_src_sel #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
        .mode     (perm_mode),
        .amt      (perm_amt),
        .quad     (quad_sel),
        .src_idx  (src_idx),
        .in_range (in_range)
    );

    xlane_route #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .LANE_W(LANE_W),
                  .NUM_ROWS(NUM_ROWS)) u_route (
        .src_vec     (src_vec),
        .src_idx     (src_idx),
        .in_range    (in_range),
        .lane_active (lane_active),
        .row_wr_en   (row_wr_en),
        .bank_wr_en  (bank_wr_en),
        .zero_fill   (zero_fill),
        .opnd_c      (opnd_c),
        .wr_c        (wr_c)
    );

    // Output register: one clock of latency, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_vec   <= '0;
            lane_wr_en <= '0;
        end else begin
            opnd_vec   <= opnd_c;
            lane_wr_en <= wr_c;
        end
    end

    // A disabled row writes nothing on the next cycle.
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row_chk
        assert_rowmask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !row_wr_en[r] |=> (lane_wr_en[r*ROW_LANES +: ROW_LANES] == '0));
    end

    // Disabled banks and inactive destination lanes are never written.
    for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane_chk
        assert_bankmask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_wr_en[L % BANK_COUNT] |=> !lane_wr_en[L]);
        assert_dest_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_active[L] |=> !lane_wr_en[L]);
    end

    // A full-wave rotate with every lane and mask enabled writes every lane.
    assert_rotate_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&lane_active) && (&row_wr_en) && (&bank_wr_en) &&
         (perm_mode == XM_WROL || perm_mode == XM_WROR)) |=> (&lane_wr_en));
endmodule

// File: tb/xlane_perm_unit_bench.sv
`timescale 1ns/1ps
module xlane_perm_unit_bench;
    localparam int N  = 64;
    localparam int DW = 32;
    localparam int NV = 25;

    // {mode[31:28], amt[27:24], quad[23:16], probe lane[15:8], expected source[7:0]}
    // An expected source of 8'hFF means the source is invalid.
    localparam logic [31:0] VEC [NV] = '{
        32'h001B0506, 32'h001B282B, 32'h1000090E, 32'h10000007,
        32'h23001114, 32'h23001EFF, 32'h2F00000F, 32'h35002520,
        32'h350024FF, 32'h4200303E, 32'h42003230, 32'h5000101F,
        32'h50003F30, 32'h6000140F, 32'h60003F2F, 32'h600003FF,
        32'h7000281F, 32'h70000AFF, 32'h80000506, 32'h80003FFF,
        32'h900000FF, 32'h9000100F, 32'hA0003F00, 32'hB000003F,
        32'h20000707
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*DW-1:0] src_vec;
    logic [3:0]      perm_mode = 4'd0;
    logic [3:0]      perm_amt = 4'd0;
    logic [7:0]      quad_sel = 8'd0;
    logic [N/16-1:0] row_wr_en = '1;
    logic [3:0]      bank_wr_en = '1;
    logic            zero_fill = 1'b1;
    logic [N-1:0]    lane_active = '1;
    logic [N*DW-1:0] opnd_vec;
    logic [N-1:0]    lane_wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlane_perm_unit #(.NUM_LANES(N), .DATA_W(DW)) u_xlane_perm_unit (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .perm_mode(perm_mode),
        .perm_amt(perm_amt), .quad_sel(quad_sel), .row_wr_en(row_wr_en),
        .bank_wr_en(bank_wr_en), .zero_fill(zero_fill),
        .lane_active(lane_active), .opnd_vec(opnd_vec), .lane_wr_en(lane_wr_en)
    );

    function automatic logic [31:0] dat(input int lane);
        return 32'hC0DE0000 + 32'(lane) * 32'h101;
    endfunction

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0:                 return "R1";
            4'd1, 4'd5:           return "R2";
            4'd2, 4'd3, 4'd4:     return "R3";
            4'd6, 4'd7:           return "R4";
            default:              return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] op(input int lane);
        return opnd_vec[lane*DW +: DW];
    endfunction

    task automatic setup(input logic [3:0] m, input logic [3:0] a, input logic [7:0] q);
        perm_mode = m; perm_amt = a; quad_sel = q;
        row_wr_en = '1; bank_wr_en = '1; zero_fill = 1'b1; lane_active = '1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) src_vec[i*DW +: DW] = dat(i);
        setup(4'd10, 4'd0, 8'h00);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R11: reset clears both outputs even with live controls
        chk("R11 reset opnd", 32'(opnd_vec != '0), 32'd0);
        chk("R11 reset wr_en", 32'(lane_wr_en != '0), 32'd0);
        rst_n = 1'b1;

        // Table walk: every pattern with zero fill on, all masks enabled
        for (int v = 0; v < NV; v++) begin
            logic [7:0] lane;
            logic [7:0] exp;
            setup(VEC[v][31:28], VEC[v][27:24], VEC[v][23:16]);
            lane = VEC[v][15:8];
            exp  = VEC[v][7:0];
            tick();
            chk(req_of(VEC[v][31:28]), op(int'(lane)), (exp == 8'hFF) ? 32'd0 : dat(int'(exp)));
            chk("R8 wr_en with zero fill", 32'(lane_wr_en[lane]), 32'd1);
        end

        // R11: the value is still the old one just before the edge, new one after
        setup(4'd10, 4'd0, 8'h00);
        tick();
        setup(4'd5, 4'd0, 8'h00);
        #1;
        chk("R11 before edge", op(16), dat(17));
        tick();
        chk("R11 after edge", op(16), dat(31));

        // R6: row 1 disabled
        setup(4'd5, 4'd0, 8'h00);
        row_wr_en = 4'b1101;
        tick();
        chk("R6 masked row", 32'(lane_wr_en[20]), 32'd0);
        chk("R6 open row", 32'(lane_wr_en[5]), 32'd1);

        // R7: bank 2 disabled
        setup(4'd5, 4'd0, 8'h00);
        bank_wr_en = 4'b1011;
        tick();
        chk("R7 masked bank", 32'(lane_wr_en[6]), 32'd0);
        chk("R7 open bank", 32'(lane_wr_en[7]), 32'd1);

        // R9: invalid source with zero fill off
        setup(4'd8, 4'd0, 8'h00);
        zero_fill = 1'b0;
        tick();
        chk("R9 invalid no-fill wr_en", 32'(lane_wr_en[63]), 32'd0);
        chk("R9 invalid no-fill opnd", op(63), 32'd0);
        chk("R9 valid lane still writes", 32'(lane_wr_en[5]), 32'd1);

        // R8: inactive source with zero fill on
        setup(4'd8, 4'd0, 8'h00);
        lane_active[6] = 1'b0;
        tick();
        chk("R8 inactive source opnd", op(5), 32'd0);
        chk("R8 inactive source wr_en", 32'(lane_wr_en[5]), 32'd1);

        // R9: inactive source with zero fill off
        setup(4'd8, 4'd0, 8'h00);
        lane_active[6] = 1'b0;
        zero_fill = 1'b0;
        tick();
        chk("R9 inactive source wr_en", 32'(lane_wr_en[5]), 32'd0);

        // R10: inactive destination is never written
        setup(4'd5, 4'd0, 8'h00);
        lane_active[5] = 1'b0;
        tick();
        chk("R10 inactive destination", 32'(lane_wr_en[5]), 32'd0);
        chk("R10 neighbour unaffected", 32'(lane_wr_en[4]), 32'd1);

        // R5: unused mode code reads self
        setup(4'd13, 4'd0, 8'h00);
        tick();
        chk("R5 reserved code identity", op(33), dat(33));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule